// File: doc/BRIEF.md
# Transmit/Receive Byte FIFO Pair with Level Flags

This block holds the two data queues of a byte-oriented serial bus controller: a transmit queue whose entries are 10 bits wide, a data byte plus two control flags that travel with it, and a receive queue of plain bytes. Both queues are 16 entries deep. The bus engine pops from the transmit side and pushes into the receive side. The register file and the interrupt logic consume the level information this block produces.

That level information has three parts. Each queue reports its occupancy zero-based, as the stored count minus one. A status byte carries the empty and full flags. A separate transmit half-empty level feeds the interrupt logic. Receive "full" does not mean physical capacity. It asserts once the stored byte count reaches a zero-based threshold supplied by software plus one. A synchronous flush input empties the transmit queue and keeps it empty for as long as it is held.

Top module: `fifo_pair_wm`

## Requirements
- R1: Each queue stores at most 16 entries. A push into a full queue is dropped and leaves the contents and the count unchanged.
- R2: `tx_occ_o` equals the stored transmit count minus one, and reads 0 when the queue is empty.
- R3: `rx_occ_o` equals the stored receive count minus one, and reads 0 when the queue is empty.
- R4: `status_o[5]` (receive full) is 1 exactly when the stored receive count is greater than or equal to `rx_thresh_i` + 1. It follows a change of `rx_thresh_i` without a clock edge.
- R5: `status_o` bit 4 is transmit full (16 stored), bit 6 is receive empty, and bit 7 is transmit empty. Bits 3..0 read 0.
- R6: While `tx_flush_i` is 1, the transmit queue is emptied at each clock edge and pushes are dropped. Transmit empty reads 1 after the first edge.
- R7: `tx_half_o` is 1 exactly when the transmit queue holds 8 or fewer entries.
- R8: A pop from an empty queue is ignored, and the count stays 0.
- R9: Entries leave in the order they entered, with all 10 transmit bits kept. The `*_data_o` ports show the oldest entry without a pop.
- R10: A push and a pop in the same cycle on a queue that is neither empty nor full leave its count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_push_i | input | 1 | Write `tx_data_i` into the transmit queue |
| tx_data_i | input | 10 | Transmit entry: byte plus two control flags |
| tx_pop_i | input | 1 | Remove the oldest transmit entry |
| tx_data_o | output | 10 | Oldest transmit entry |
| tx_flush_i | input | 1 | Synchronous transmit flush, level sensitive |
| rx_push_i | input | 1 | Write `rx_data_i` into the receive queue |
| rx_data_i | input | 8 | Received byte |
| rx_pop_i | input | 1 | Remove the oldest received byte |
| rx_data_o | output | 8 | Oldest received byte |
| rx_thresh_i | input | 4 | Zero-based receive-full threshold |
| tx_occ_o | output | 4 | Transmit occupancy, zero-based |
| rx_occ_o | output | 4 | Receive occupancy, zero-based |
| status_o | output | 8 | Status flags: bits 7..4 as in R5 and R4 |
| tx_half_o | output | 1 | Transmit half-empty level |

## Verification
Each push, pop or flush changes a count register at the next rising edge. Occupancy, the flags, the half-empty level and the head data follow from that register through logic with no further register, so all of them are valid one edge after the stimulus. A threshold change takes effect in the same cycle. The bench drives inputs on the falling edge, lets exactly one rising edge pass, and samples on the following falling edge before it drives anything new. The threshold is also re-sampled with no edge in between.

// File: rtl/fifo_pair_pkg.sv
package fifo_pair_pkg;
  parameter int unsigned DEPTH     = 16;
  parameter int unsigned TX_W      = 10;
  parameter int unsigned RX_W      = 8;
  parameter int unsigned OCC_W     = $clog2(DEPTH);
  parameter int unsigned CNT_W     = $clog2(DEPTH + 1);
  parameter int unsigned HALF_LVL  = DEPTH / 2;
  parameter int unsigned ST_TX_FULL  = 4;
  parameter int unsigned ST_RX_FULL  = 5;
  parameter int unsigned ST_RX_EMPTY = 6;
  parameter int unsigned ST_TX_EMPTY = 7;
endpackage

// File: rtl/wm_fifo.sv
module wm_fifo #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] data_o,
  output logic [CW-1:0]    cnt_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wr_q, rd_q;
  logic [CW-1:0]    cnt_q;
  logic             do_push, do_pop;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  // eligibility judged on the pre-edge count
  assign do_push = push_i && !flush_i && (cnt_q != CW'(DEPTH));
  assign do_pop  = pop_i  && !flush_i && (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= bump(wr_q);
      if (do_pop)  rd_q <= bump(rd_q);
      if (do_push && !do_pop)      cnt_q <= cnt_q + CW'(1);
      else if (do_pop && !do_push) cnt_q <= cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= data_i;
  end

  assign data_o = mem_q[rd_q];
  assign cnt_o  = cnt_q;

  a_r1_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
  a_r1_push_full_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i && !flush_i && cnt_q == CW'(DEPTH)) |=> (cnt_q == CW'(DEPTH)) && $stable(wr_q));
  a_r8_pop_empty_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && !flush_i && cnt_q == '0) |=> (cnt_q == '0) && $stable(rd_q));
  a_r6_flush_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (cnt_q == '0));
  a_r10_push_pop_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i && !flush_i && cnt_q != '0 && cnt_q != CW'(DEPTH)) |=> $stable(cnt_q));
endmodule

// File: rtl/fifo_levels.sv
module fifo_levels
  import fifo_pair_pkg::*;
#(
  parameter int unsigned LVL_DEPTH = DEPTH,
  parameter int unsigned LVL_HALF  = LVL_DEPTH / 2,
  localparam int unsigned AW = $clog2(LVL_DEPTH),
  localparam int unsigned CW = $clog2(LVL_DEPTH + 1)
) (
  input  logic [CW-1:0] tx_cnt_i,
  input  logic [CW-1:0] rx_cnt_i,
  input  logic [AW-1:0] rx_thresh_i,
  output logic [AW-1:0] tx_occ_o,
  output logic [AW-1:0] rx_occ_o,
  output logic [7:0]    status_o,
  output logic          tx_half_o
);
  function automatic logic [AW-1:0] zb(input logic [CW-1:0] c);
    return (c == '0) ? '0 : AW'(c - CW'(1));
  endfunction

  logic [CW-1:0] rx_trip;
  assign rx_trip = CW'(rx_thresh_i) + CW'(1);

  assign tx_occ_o  = zb(tx_cnt_i);
  assign rx_occ_o  = zb(rx_cnt_i);
  assign tx_half_o = (tx_cnt_i <= CW'(LVL_HALF));

  always_comb begin
    status_o              = '0;
    status_o[ST_TX_FULL]  = (tx_cnt_i == CW'(LVL_DEPTH));
    status_o[ST_RX_FULL]  = (rx_cnt_i >= rx_trip);
    status_o[ST_RX_EMPTY] = (rx_cnt_i == '0);
    status_o[ST_TX_EMPTY] = (tx_cnt_i == '0);
  end

  a_r5_empty_full_exclusive: assert property (@(posedge status_o[ST_TX_FULL])
    !status_o[ST_TX_EMPTY]);
endmodule

// File: rtl/fifo_pair_wm.sv
module fifo_pair_wm
  import fifo_pair_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tx_push_i,
  input  logic [TX_W-1:0]  tx_data_i,
  input  logic             tx_pop_i,
  output logic [TX_W-1:0]  tx_data_o,
  input  logic             tx_flush_i,
  input  logic             rx_push_i,
  input  logic [RX_W-1:0]  rx_data_i,
  input  logic             rx_pop_i,
  output logic [RX_W-1:0]  rx_data_o,
  input  logic [OCC_W-1:0] rx_thresh_i,
  output logic [OCC_W-1:0] tx_occ_o,
  output logic [OCC_W-1:0] rx_occ_o,
  output logic [7:0]       status_o,
  output logic             tx_half_o
);
  logic [CNT_W-1:0] tx_cnt, rx_cnt;

  wm_fifo #(.WIDTH(TX_W), .DEPTH(DEPTH)) u_tx (
    .clk_i, .rst_ni, .flush_i(tx_flush_i),
    .push_i(tx_push_i), .data_i(tx_data_i),
    .pop_i(tx_pop_i), .data_o(tx_data_o), .cnt_o(tx_cnt)
  );

  wm_fifo #(.WIDTH(RX_W), .DEPTH(DEPTH)) u_rx (
    .clk_i, .rst_ni, .flush_i(1'b0),
    .push_i(rx_push_i), .data_i(rx_data_i),
    .pop_i(rx_pop_i), .data_o(rx_data_o), .cnt_o(rx_cnt)
  );

  fifo_levels #(.LVL_DEPTH(DEPTH), .LVL_HALF(HALF_LVL)) u_lvl (
    .tx_cnt_i(tx_cnt), .rx_cnt_i(rx_cnt), .rx_thresh_i,
    .tx_occ_o, .rx_occ_o, .status_o, .tx_half_o
  );

  a_r7_half_at_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[ST_TX_EMPTY] |-> tx_half_o);
  a_r6_flush_reads_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_flush_i |=> status_o[ST_TX_EMPTY]);
endmodule

// File: tb/test_fifo_pair_wm.sv
`timescale 1ns/1ps
module test_fifo_pair_wm;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_push = 0, tx_pop = 0, tx_flush = 0, rx_push = 0, rx_pop = 0;
  logic [9:0] tx_din = '0;
  logic [7:0] rx_din = '0;
  logic [3:0] thresh = 4'd2;
  logic [9:0] tx_dout;
  logic [7:0] rx_dout;
  logic [3:0] tx_occ, rx_occ;
  logic [7:0] status;
  logic       half;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  fifo_pair_wm i_fifo_pair_wm (
    .clk_i(clk), .rst_ni(rst_n),
    .tx_push_i(tx_push), .tx_data_i(tx_din), .tx_pop_i(tx_pop), .tx_data_o(tx_dout),
    .tx_flush_i(tx_flush),
    .rx_push_i(rx_push), .rx_data_i(rx_din), .rx_pop_i(rx_pop), .rx_data_o(rx_dout),
    .rx_thresh_i(thresh), .tx_occ_o(tx_occ), .rx_occ_o(rx_occ),
    .status_o(status), .tx_half_o(half)
  );

  typedef struct packed {
    logic tp, tq, fl, rp, rq;
    logic [3:0] th;
    logic [3:0] st;   // expected status[7:4]
    logic [3:0] tocc, rocc;
    logic hf;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1,0,0,0,0, 4'd2, 4'b0100, 4'd0, 4'd0, 1},  // R2 first tx entry
    '{1,0,0,1,0, 4'd2, 4'b0000, 4'd1, 4'd0, 1},  // R3 first rx byte
    '{0,0,0,1,0, 4'd2, 4'b0000, 4'd1, 4'd1, 1},
    '{0,0,0,1,0, 4'd2, 4'b0010, 4'd1, 4'd2, 1},  // R4 3 >= 2+1
    '{0,0,0,0,1, 4'd2, 4'b0000, 4'd1, 4'd1, 1},  // R4 drop below
    '{0,0,0,0,0, 4'd1, 4'b0010, 4'd1, 4'd1, 1},  // R4 threshold lowered
    '{1,1,0,0,0, 4'd1, 4'b0010, 4'd1, 4'd1, 1},  // R10 tx push+pop
    '{0,0,0,1,1, 4'd1, 4'b0010, 4'd1, 4'd1, 1},  // R10 rx push+pop
    '{1,0,1,0,0, 4'd1, 4'b1010, 4'd0, 4'd1, 1},  // R6 flush with push
    '{0,1,0,0,0, 4'd1, 4'b1010, 4'd0, 4'd1, 1},  // R8 tx pop empty
    '{0,0,0,0,1, 4'd1, 4'b1000, 4'd0, 4'd0, 1},
    '{0,0,0,0,1, 4'd1, 4'b1100, 4'd0, 4'd0, 1},  // R5 rx empty
    '{0,0,0,0,1, 4'd1, 4'b1100, 4'd0, 4'd0, 1},  // R8 rx pop empty
    '{0,0,0,1,0, 4'd0, 4'b1010, 4'd0, 4'd0, 1}   // R4 threshold zero
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    tx_push = 0; tx_pop = 0; tx_flush = 0; rx_push = 0; rx_pop = 0;
  endtask

  // one edge then sample at the next falling edge
  task automatic step();
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R5 reset status", {24'd0, status}, 32'h0000_00C0);
    chk("R2 reset tx occ", {28'd0, tx_occ}, 32'd0);
    chk("R3 reset rx occ", {28'd0, rx_occ}, 32'd0);
    rst_n = 1'b1;
    step();

    for (int i = 0; i < NV; i++) begin
      tx_push = VECS[i].tp; tx_pop = VECS[i].tq; tx_flush = VECS[i].fl;
      rx_push = VECS[i].rp; rx_pop = VECS[i].rq; thresh = VECS[i].th;
      tx_din = 10'(i + 10'h200); rx_din = 8'(i + 8'h40);
      step();
      idle();
      chk($sformatf("R5 status v%0d", i), {28'd0, status[7:4]}, {28'd0, VECS[i].st});
      chk($sformatf("R5 low bits v%0d", i), {28'd0, status[3:0]}, 32'd0);
      chk($sformatf("R2 tx occ v%0d", i), {28'd0, tx_occ}, {28'd0, VECS[i].tocc});
      chk($sformatf("R3 rx occ v%0d", i), {28'd0, rx_occ}, {28'd0, VECS[i].rocc});
      chk($sformatf("R7 half v%0d", i), {31'd0, half}, {31'd0, VECS[i].hf});
    end

    // R4 same-cycle threshold effect (1 byte stored)
    thresh = 4'd1; #1;
    chk("R4 thresh 1 no edge", {31'd0, status[5]}, 32'd0);
    thresh = 4'd0; #1;
    chk("R4 thresh 0 no edge", {31'd0, status[5]}, 32'd1);

    // R9 rx head shows byte 0x4D (pushed in vector 13)
    chk("R9 rx head", {24'd0, rx_dout}, 32'h4D);

    // fill transmit queue, R7 and R1
    tx_flush = 1; step(); idle();
    for (int k = 0; k < 16; k++) begin
      tx_push = 1; tx_din = 10'(10'h3F0 - k);
      step(); idle();
      if (k == 7) chk("R7 half at 8", {31'd0, half}, 32'd1);
      if (k == 8) chk("R7 half at 9", {31'd0, half}, 32'd0);
    end
    chk("R1 tx full flag", {31'd0, status[4]}, 32'd1);
    chk("R2 tx occ full", {28'd0, tx_occ}, 32'd15);
    tx_push = 1; tx_din = 10'h155; step(); idle();
    chk("R1 push while full occ", {28'd0, tx_occ}, 32'd15);
    chk("R9 head 10 bits", {22'd0, tx_dout}, 32'h3F0);

    // R10 at full: pop succeeds, push dropped
    tx_push = 1; tx_pop = 1; tx_din = 10'h0AA; step(); idle();
    chk("R1 full push+pop occ", {28'd0, tx_occ}, 32'd14);

    for (int k = 1; k < 16; k++) begin
      chk($sformatf("R9 order %0d", k), {22'd0, tx_dout}, 32'(10'h3F0 - k));
      tx_pop = 1; step(); idle();
    end
    chk("R1 dropped push not stored", {31'd0, status[7]}, 32'd1);

    // R6 hold: flush held while pushing
    tx_flush = 1; tx_push = 1; tx_din = 10'h001; step();
    chk("R6 held flush empty", {31'd0, status[7]}, 32'd1);
    step(); idle();
    chk("R6 held flush occ", {28'd0, tx_occ}, 32'd0);
    chk("R6 held flush tx empty", {31'd0, status[7]}, 32'd1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule